// File: doc/BRIEF.md
# Stack Machine Top-of-Stack Datapath

This block is the execution datapath of a small stack processor. The top of the stack lives in a register, and every deeper element lives in a single-port data memory addressed by a stack pointer. Four local-variable registers sit beside the top-of-stack register, so that local loads and stores avoid memory traffic. Instructions arrive one at a time as an opcode plus an argument on a valid/ready stream. The block executes a fixed set of eight stack operations: literal push, local get and put, memory load and store, indexed load and store, and add.

A dedicated pointer unit moves the stack pointer by +1 or -1 without the adder. Within one clock, the first half drives the memory address and data. The pointer and the destination registers capture their values on the clock edge that ends the cycle. A push is a pre-increment write and a pop is a read followed by a post-decrement, and each takes one cycle. The adder is free for the indexed address or for the add result.

The stream has back-pressure. `in_ready` is high whenever no instruction is in progress. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high, and the cycle of that edge is its first execution cycle. A multi-cycle instruction holds `in_ready` low until its final cycle has completed. While `in_ready` is low, the input fields are ignored and the producer must hold them.

Top module: `stk_tos_datapath`

## Requirements
- R1: After reset, `in_ready`=1, `ts_o`=0, `sp_o`=0 and `err_o`=0. An instruction is accepted only on an edge with `in_valid`=1 and `in_ready`=1. `in_ready` then stays low for N-1 cycles, where N is the cycle count of the instruction. Opcode encodings: get=0, lit=1, ld=2, add=3, st=4, put=5, ldx=6, stx=7.
- R2: get k, with k from 1 to 4, takes 1 cycle. It writes the old top to memory[sp+1], sets sp to sp+1 and loads the top with local k.
- R3: lit x takes 1 cycle. It pushes the old top as in R2 and loads the top with x.
- R4: ld a takes 2 cycles. It pushes the old top, then loads the top with memory[a mod 2^AW].
- R5: add takes 2 cycles. It pops the element below the top, sets the top to top+element mod 2^DW, and leaves sp reduced by 1.
- R6: st a takes 2 cycles. It writes the top to memory[a mod 2^AW], then pops the next element into the top.
- R7: put k, with k from 1 to 4, takes 1 cycle. It copies the top into local k and pops the next element into the top.
- R8: ldx takes 2 cycles. With base b just below the top and index i on top, it pops b and loads the top with memory[(b+i) mod 2^AW].
- R9: stx takes 4 cycles. With base b, index i and value v on top, it pops i, then b, writes v to memory[(i+b) mod 2^AW], then pops the next element into the top. The net change to sp is -3.
- R10: get or put with k outside 1 to 4 takes 1 cycle and sets `err_o`. The top, sp and the locals stay unchanged. `err_o` clears when the next valid instruction is accepted.
- R11: The stack pointer wraps modulo 2^AW in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block can accept an instruction |
| in_op | input | 3 | Opcode (R1 encoding) |
| in_arg | input | DW | Literal, address or local index |
| ts_o | output | DW | Top-of-stack register |
| sp_o | output | AW | Stack pointer |
| err_o | output | 1 | Bad local index on the last accepted instruction |

## Verification
The bench drives enough literal pushes to wrap the pointer past the top of memory. A pointer unit that saturated or used extra width would then leave `sp_o` and later pops wrong. It sweeps every local index from 0 to 7 on get and put: a design that decoded 0 or 5 as a real local, or that still pushed on an error, would disturb later gets or the pointer. Adds use operands near the word limit to catch a missing wrap, and the indexed operations use base+index sums that cross the memory size. Each instruction's busy time is counted, so a push or pop that took an extra cycle, or a ready that rose early, is reported.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_GET = 3'd0, OP_LIT = 3'd1, OP_LD  = 3'd2, OP_ADD = 3'd3,
    OP_ST  = 3'd4, OP_PUT = 3'd5, OP_LDX = 3'd6, OP_STX = 3'd7
  } op_e;

  typedef enum logic [1:0] {SP_HOLD = 2'd0, SP_INC = 2'd1, SP_DEC = 2'd2} sp_sel_e;
  typedef enum logic [1:0] {MA_SP = 2'd0, MA_SP1 = 2'd1, MA_ARG = 2'd2, MA_SUM = 2'd3} ma_e;
  typedef enum logic [2:0] {
    TS_HOLD = 3'd0, TS_VREG = 3'd1, TS_ARG = 3'd2, TS_MEM = 3'd3, TS_SUM = 3'd4
  } ts_sel_e;

  typedef struct packed {
    sp_sel_e sp_sel;
    ma_e     ma;
    logic    mem_we;
    ts_sel_e ts_sel;
    logic    ff_we;
    logic    nx_we;
    logic    v_we;
    logic    alu_nx;
    logic    last;
    logic    bad;
  } ctl_t;
endpackage

// File: rtl/stk_sp_unit.sv
module stk_sp_unit
  import stk_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sp_sel_e       sel,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_inc,
  output logic [AW-1:0] sp_dec
);
  logic [AW-1:0] sp_nxt;

  // Both neighbours are available during the first half of the cycle.
  assign sp_inc = sp + 1'b1;
  assign sp_dec = sp - 1'b1;

  always_comb begin
    case (sel)
      SP_INC:  sp_nxt = sp_inc;
      SP_DEC:  sp_nxt = sp_dec;
      default: sp_nxt = sp;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sp <= '0;
    else        sp <= sp_nxt;
  end
endmodule

// File: rtl/stk_vcache.sv
module stk_vcache #(
  parameter int DW = 16,
  parameter int NV = 4,
  localparam int IW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] regs [NV];

  for (genvar g = 0; g < NV; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                          regs[g] <= '0;
      else if (wr_en && idx == IW'(g))     regs[g] <= wr_data;
    end
  end

  assign rd_data = regs[idx];
endmodule

// File: rtl/stk_mem.sv
module stk_mem #(
  parameter int AW = 6,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  // The address settles early in the cycle; the write ends at the edge.
  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DW = 16,
  parameter int NV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic [DW-1:0] in_arg,
  output logic          in_ready,
  output ctl_t          ctl,
  output logic [DW-1:0] cur_arg,
  output logic          err
);
  logic          busy_q;
  logic [1:0]    step_q;
  op_e           op_q;
  logic [DW-1:0] arg_q;

  logic          fire;
  logic          act;
  op_e           cur_op;
  logic [1:0]    step;
  logic          idx_ok;

  assign in_ready = !busy_q;
  assign fire     = in_valid && !busy_q;
  assign act      = fire || busy_q;
  assign cur_op   = busy_q ? op_q : op_e'(in_op);
  assign cur_arg  = busy_q ? arg_q : in_arg;
  assign step     = busy_q ? step_q : 2'd0;
  assign idx_ok   = (cur_arg >= DW'(1)) && (cur_arg <= DW'(NV));

  always_comb begin
    ctl = '0;
    if (act) begin
      unique case (cur_op)
        OP_GET: begin
          ctl.last = 1'b1;
          if (idx_ok) begin
            ctl.ma = MA_SP1; ctl.mem_we = 1'b1; ctl.sp_sel = SP_INC; ctl.ts_sel = TS_VREG;
          end else begin
            ctl.bad = 1'b1;
          end
        end
        OP_LIT: begin
          ctl.ma = MA_SP1; ctl.mem_we = 1'b1; ctl.sp_sel = SP_INC; ctl.ts_sel = TS_ARG;
          ctl.last = 1'b1;
        end
        OP_LD: begin
          if (step == 2'd0) begin
            ctl.ma = MA_SP1; ctl.mem_we = 1'b1; ctl.sp_sel = SP_INC;
          end else begin
            ctl.ma = MA_ARG; ctl.ts_sel = TS_MEM; ctl.last = 1'b1;
          end
        end
        OP_ADD: begin
          if (step == 2'd0) begin
            ctl.ma = MA_SP; ctl.ff_we = 1'b1; ctl.sp_sel = SP_DEC;
          end else begin
            ctl.ts_sel = TS_SUM; ctl.last = 1'b1;
          end
        end
        OP_ST: begin
          if (step == 2'd0) begin
            ctl.ma = MA_ARG; ctl.mem_we = 1'b1;
          end else begin
            ctl.ma = MA_SP; ctl.ts_sel = TS_MEM; ctl.sp_sel = SP_DEC; ctl.last = 1'b1;
          end
        end
        OP_PUT: begin
          ctl.last = 1'b1;
          if (idx_ok) begin
            ctl.v_we = 1'b1; ctl.ma = MA_SP; ctl.ts_sel = TS_MEM; ctl.sp_sel = SP_DEC;
          end else begin
            ctl.bad = 1'b1;
          end
        end
        OP_LDX: begin
          if (step == 2'd0) begin
            ctl.ma = MA_SP; ctl.ff_we = 1'b1; ctl.sp_sel = SP_DEC;
          end else begin
            ctl.ma = MA_SUM; ctl.ts_sel = TS_MEM; ctl.last = 1'b1;
          end
        end
        OP_STX: begin
          case (step)
            2'd0: begin ctl.ma = MA_SP; ctl.nx_we = 1'b1; ctl.sp_sel = SP_DEC; end
            2'd1: begin ctl.ma = MA_SP; ctl.ff_we = 1'b1; ctl.sp_sel = SP_DEC; end
            2'd2: begin ctl.ma = MA_SUM; ctl.alu_nx = 1'b1; ctl.mem_we = 1'b1; end
            default: begin
              ctl.ma = MA_SP; ctl.ts_sel = TS_MEM; ctl.sp_sel = SP_DEC; ctl.last = 1'b1;
            end
          endcase
        end
        default: ctl.last = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      op_q   <= OP_GET;
      arg_q  <= '0;
      err    <= 1'b0;
    end else begin
      if (fire) err <= ctl.bad;
      if (fire && !ctl.last) begin
        busy_q <= 1'b1;
        step_q <= 2'd1;
        op_q   <= op_e'(in_op);
        arg_q  <= in_arg;
      end else if (busy_q) begin
        if (ctl.last) begin
          busy_q <= 1'b0;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stk_tos_datapath.sv
module stk_tos_datapath
  import stk_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int NV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [DW-1:0] in_arg,
  output logic [DW-1:0] ts_o,
  output logic [AW-1:0] sp_o,
  output logic          err_o
);
  localparam int IW = (NV > 1) ? $clog2(NV) : 1;

  ctl_t          ctl;
  logic [DW-1:0] cur_arg;
  logic [AW-1:0] sp, sp_inc, sp_dec;
  logic [DW-1:0] ts_q, ff_q, nx_q;
  logic [DW-1:0] sum;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] v_rdata;
  logic [IW-1:0] v_idx;
  logic [DW-1:0] ts_nxt;

  stk_ctrl #(.DW(DW), .NV(NV)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_arg(in_arg),
    .in_ready(in_ready), .ctl(ctl), .cur_arg(cur_arg), .err(err_o)
  );

  stk_sp_unit #(.AW(AW)) u_sp (
    .clk(clk), .rst_n(rst_n), .sel(ctl.sp_sel), .sp(sp), .sp_inc(sp_inc), .sp_dec(sp_dec)
  );

  // Local index k (1..NV) selects register k-1.
  assign v_idx = cur_arg[IW-1:0] - 1'b1;

  stk_vcache #(.DW(DW), .NV(NV)) u_vc (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl.v_we), .idx(v_idx), .wr_data(ts_q), .rd_data(v_rdata)
  );

  // Single adder: operand a is the top or the popped index, b is the popped base.
  assign sum = (ctl.alu_nx ? nx_q : ts_q) + ff_q;

  always_comb begin
    case (ctl.ma)
      MA_SP1:  mem_addr = sp_inc;
      MA_ARG:  mem_addr = cur_arg[AW-1:0];
      MA_SUM:  mem_addr = sum[AW-1:0];
      default: mem_addr = sp;
    endcase
  end

  stk_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(ctl.mem_we), .addr(mem_addr), .wdata(ts_q), .rdata(mem_rdata)
  );

  always_comb begin
    case (ctl.ts_sel)
      TS_VREG: ts_nxt = v_rdata;
      TS_ARG:  ts_nxt = cur_arg;
      TS_MEM:  ts_nxt = mem_rdata;
      TS_SUM:  ts_nxt = sum;
      default: ts_nxt = ts_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_q <= '0;
      ff_q <= '0;
      nx_q <= '0;
    end else begin
      ts_q <= ts_nxt;
      if (ctl.ff_we) ff_q <= mem_rdata;
      if (ctl.nx_we) nx_q <= mem_rdata;
    end
  end

  assign ts_o = ts_q;
  assign sp_o = sp;
endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int NV = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_op,
  input logic [DW-1:0] in_arg,
  input logic [DW-1:0] ts_o,
  input logic [AW-1:0] sp_o,
  input logic          err_o
);
  logic fire, good;
  assign fire = in_valid && in_ready;
  assign good = (in_arg >= DW'(1)) && (in_arg <= DW'(NV));

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid)); // R1

  AST_GET_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'd0 && good |=> in_ready && sp_o == AW'($past(sp_o) + 1'b1)); // R2

  AST_LIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'd1 |=> in_ready && ts_o == $past(in_arg)); // R3

  AST_ADD_POP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'd3 |=> !in_ready && sp_o == AW'($past(sp_o) - 1'b1)); // R5

  AST_PUT_POP: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'd5 && good |=> in_ready && sp_o == AW'($past(sp_o) - 1'b1)); // R7

  AST_STX_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'd7 |=> !in_ready); // R9

  AST_BAD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_op == 3'd0 || in_op == 3'd5) && !good
      |=> err_o && in_ready && $stable(ts_o) && $stable(sp_o)); // R10
endmodule

bind stk_tos_datapath stk_checker #(.AW(AW), .DW(DW), .NV(NV)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .in_arg(in_arg), .ts_o(ts_o), .sp_o(sp_o), .err_o(err_o)
);

// File: tb/sim_stk_tos_datapath.sv
`timescale 1ns/1ps
module sim_stk_tos_datapath;
  localparam int AW = 6, DW = 16, NV = 4, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, in_valid, in_ready, err_o;
  logic [2:0]    in_op;
  logic [DW-1:0] in_arg, ts_o;
  logic [AW-1:0] sp_o;

  stk_tos_datapath #(.AW(AW), .DW(DW), .NV(NV)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_arg(in_arg), .ts_o(ts_o), .sp_o(sp_o), .err_o(err_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] m_v [1:NV];
  logic [DW-1:0] m_ts;
  logic [AW-1:0] m_sp;
  logic          m_err;

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic m_push();
    m_sp = m_sp + 1'b1;
    m_mem[m_sp] = m_ts;
  endtask

  task automatic m_pop(output logic [DW-1:0] d);
    d = m_mem[m_sp];
    m_sp = m_sp - 1'b1;
  endtask

  task automatic do_op(input logic [2:0] op, input logic [DW-1:0] arg);
    string req;
    int ecyc, cyc;
    logic [DW-1:0] ff, nx;
    logic good;
    good = (arg >= 1) && (arg <= NV);
    m_err = 1'b0;
    case (op)
      3'd0: if (good) begin req = "R2"; ecyc = 1; m_push(); m_ts = m_v[arg[2:0]]; end
            else begin req = "R10"; ecyc = 1; m_err = 1'b1; end
      3'd1: begin req = "R3"; ecyc = 1; m_push(); m_ts = arg; end
      3'd2: begin req = "R4"; ecyc = 2; m_push(); m_ts = m_mem[arg[AW-1:0]]; end
      3'd3: begin req = "R5"; ecyc = 2; m_pop(ff); m_ts = m_ts + ff; end
      3'd4: begin req = "R6"; ecyc = 2; m_mem[arg[AW-1:0]] = m_ts; m_pop(m_ts); end
      3'd5: if (good) begin req = "R7"; ecyc = 1; m_v[arg[2:0]] = m_ts; m_pop(m_ts); end
            else begin req = "R10"; ecyc = 1; m_err = 1'b1; end
      3'd6: begin req = "R8"; ecyc = 2; m_pop(ff); m_ts = m_mem[AW'(m_ts + ff)]; end
      default: begin
        req = "R9"; ecyc = 4; m_pop(nx); m_pop(ff);
        m_mem[AW'(nx + ff)] = m_ts; m_pop(m_ts);
      end
    endcase
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_arg = arg;
    @(posedge clk); #1;
    in_valid = 1'b0;
    cyc = 1;
    while (!in_ready && cyc < 10) begin
      @(posedge clk); #1;
      cyc++;
    end
    check(req, "cycles (R1 ready)", cyc, ecyc);
    check(req, "ts", ts_o, m_ts);
    check(req, "sp", sp_o, m_sp);
    check(req, "err", err_o, m_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_arg = '0;
    m_ts = '0; m_sp = '0; m_err = 1'b0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    for (int i = 1; i <= NV; i++) m_v[i] = '0;
    repeat (3) @(posedge clk); #1;
    check("R1", "reset ready", in_ready, 1);
    check("R1", "reset ts", ts_o, 0);
    check("R1", "reset sp", sp_o, 0);
    check("R1", "reset err", err_o, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3 / R11: push enough literals to fill and wrap the memory
    for (int i = 0; i < 70; i++) do_op(3'd1, DW'(i * 37 + 5));
    check("R11", "sp after wrap", sp_o, 70 % DEPTH);

    // R7 / R10 / R2: every index 0..7 on put and get
    for (int k = 0; k < 8; k++) do_op(3'd5, DW'(k));
    for (int k = 0; k < 8; k++) do_op(3'd0, DW'(k));
    do_op(3'd0, 16'h0104);  // upper bits set: out of range (R10)

    // R6 / R4: stores then loads at spread addresses
    for (int k = 0; k < 8; k++) begin
      do_op(3'd4, DW'(k * 9 + 64));
      do_op(3'd2, DW'(k * 9));
    end

    // R5: operands around the word limit
    for (int i = 0; i < 12; i++) begin
      do_op(3'd1, DW'(16'hFFF0 + i * 3));
      do_op(3'd1, DW'(i * 1234));
      do_op(3'd3, '0);
    end

    // R8: base+index crossing the memory size
    for (int i = 0; i < 6; i++) begin
      do_op(3'd1, DW'(i * 11));
      do_op(3'd1, DW'(i * 7 + 60));
      do_op(3'd6, '0);
    end

    // R9: indexed stores read back with ld
    for (int i = 0; i < 6; i++) begin
      do_op(3'd1, DW'(i * 13));
      do_op(3'd1, DW'(i * 5 + 50));
      do_op(3'd1, DW'(16'hA500 + i));
      do_op(3'd7, '0);
      do_op(3'd2, DW'((i * 13 + i * 5 + 50) % DEPTH));
    end

    // R11: pop below zero
    while (m_sp != 0) do_op(3'd3, '0);
    do_op(3'd3, '0);
    check("R11", "sp wrap down", sp_o, DEPTH - 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule